// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the register face of a PS/2 keyboard or mouse port on a 32-bit, word-addressed peripheral bus with a 4 KB window. Software programs an 8-bit control word and an 8-bit clock-divisor word, and polls a status word. It takes received bytes from a data register and sends bytes by writing that same register. A read-only identification window sits at the top of the space.

On the device side, received bytes arrive over a valid/ready handshake. A read of the data register takes a byte only when one is pending. Otherwise the read returns the byte taken last time. Written bytes leave as a one-cycle strobe that carries the low eight bits. A single registered, level-sensitive interrupt combines a receive term with a transmit term. The transmit term is set by its enable alone, because the transmitter always reports empty.

Bus transfers last one cycle: `bus_sel` qualifies the cycle and `bus_wr` selects the direction. Read data appears on `bus_rdata` after the clock edge that samples the read, and it holds until the next read.

Top module: `kbd_port_regs`

## Requirements
- R1: After reset, the control word, the divisor word and the stored byte read as 0, and `irq` and `tx_strobe` are low.
- R2: A write to offset 0x00 stores bits 7:0 as the control word, and a write to offset 0x0C stores bits 7:0 as the divisor word. A read of either offset returns the stored value with bits 31:8 equal to 0.
- R3: A read of offset 0x04 returns bit 6 = 1, bit 4 = pending flag and bit 2 = XOR of the 8 bits of the stored byte. All other bits are 0.
- R4: A read of offset 0x08 while a byte is pending raises `rx_ready` in that cycle. It returns `rx_data` in bits 7:0 and keeps that byte as the stored byte.
- R5: A read of offset 0x08 with nothing pending leaves `rx_ready` low and returns the stored byte again.
- R6: The pending flag follows `rx_valid` one cycle late. It is cleared in the cycle of an accepted pop, so a read on the very next cycle sees it clear.
- R7: A read of offset 0x10 returns bit 0 = pending flag and bit 1 = 1. All other bits are 0.
- R8: `irq` is a register. It is high one cycle after (pending AND control bit 4) OR control bit 3 holds, and low one cycle after that condition is false.
- R9: A write to offset 0x08 gives a `tx_strobe` pulse exactly one cycle long, in the next cycle, with `tx_data` equal to the written bits 7:0.
- R10: Reads of offsets 0xFE0 to 0xFFC, one word each, return in order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A read of an undefined offset returns 0. Writes to offsets 0x04, 0x10, the identification window or undefined offsets change no register and give no `tx_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus transfer this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the read edge |
| rx_valid | input | 1 | Device side has a byte available |
| rx_data | input | 8 | Byte offered by the device side |
| rx_ready | output | 1 | Byte accepted this cycle |
| tx_strobe | output | 1 | One-cycle send strobe |
| tx_data | output | 8 | Byte to send |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after a status read on the cycle right after a pop. A design that cleared pending late would report a full receiver there, and could take a second byte. It reads the data register with nothing pending, where a wrong design would pulse `rx_ready` or return a stale device byte instead of the kept one. It compares the parity bit against bytes of both odd and even weight, which catches parity taken from the offered byte rather than the stored one. It also writes to read-only and undefined offsets, where a loose decoder would corrupt the control or divisor word or send a stray strobe.

// File: rtl/kbd_port_regs.sv
module kbd_port_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_IRQS = ADDR_W'(12'h010);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        last_q;
  logic              pend_q;
  logic [DATA_W-1:0] rd_mux;
  logic [7:0]        id_byte;

  wire rd     = bus_sel & ~bus_wr;
  wire wr     = bus_sel & bus_wr;
  wire id_hit = &bus_addr[ADDR_W-1:5];
  wire pop    = rd & (bus_addr == A_DATA) & pend_q & rx_valid;

  assign rx_ready = pop;

  always_comb begin
    case (bus_addr[4:2])
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) rd_mux = DATA_W'(id_byte);
    else begin
      case (bus_addr)
        A_CTRL: rd_mux = DATA_W'(ctrl_q);
        A_STAT: rd_mux = DATA_W'({1'b1, 1'b0, pend_q, 1'b0, ^last_q, 2'b00});
        A_DATA: rd_mux = DATA_W'(pop ? rx_data : last_q);
        A_DIV:  rd_mux = DATA_W'(div_q);
        A_IRQS: rd_mux = DATA_W'({1'b1, pend_q});
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      last_q    <= '0;
      pend_q    <= 1'b0;
      irq       <= 1'b0;
      tx_strobe <= 1'b0;
      tx_data   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr && !id_hit && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr && !id_hit && bus_addr == A_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
      tx_strobe <= wr && !id_hit && bus_addr == A_DATA;
      if (wr && !id_hit && bus_addr == A_DATA) tx_data <= bus_wdata[7:0];
      if (pop) last_q <= rx_data;
      pend_q <= pop ? 1'b0 : rx_valid;
      irq    <= (pend_q & ctrl_q[4]) | ctrl_q[3];
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/kbd_port_regs_chk.sv
module kbd_port_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              pend_q
);
  p_pop_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
  p_pop_returns_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> bus_rdata[7:0] == $past(rx_data));
  p_no_double_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  p_irq_tx_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[3] |=> irq);
  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[3] && !(pend_q && ctrl_q[4])) |=> !irq);
  p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(12'h008)));
  p_tx_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(12'h004)) |=> bus_rdata[6]);
  p_irqs_bit1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(12'h010)) |=> bus_rdata[1]);
endmodule

bind kbd_port_regs kbd_port_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .tx_strobe(tx_strobe), .irq(irq), .ctrl_q(ctrl_q), .pend_q(pend_q)
);

// File: tb/test_kbd_port_regs.sv
`timescale 1ns/1ps
module test_kbd_port_regs;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_strobe, irq;
  logic [7:0] tx_data;

  kbd_port_regs i_kbd_port_regs (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_ctrl = 0, m_div = 0, m_last = 0, m_byte = 0;
  bit m_pend = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_irq();
    chk("R8 irq", {31'b0, irq}, {31'b0, (m_pend & m_ctrl[4]) | m_ctrl[3]});
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a[11:5] == 7'h7F) begin
      case (a[4:2])
        3'd0: return 32'h50; 3'd1: return 32'h10; 3'd2: return 32'h04; 3'd3: return 32'h00;
        3'd4: return 32'h0D; 3'd5: return 32'hF0; 3'd6: return 32'h05; default: return 32'hB1;
      endcase
    end
    case (a)
      12'h000: return {24'b0, m_ctrl};
      12'h004: return {25'b0, 1'b1, 1'b0, m_pend, 1'b0, ^m_last, 2'b0};
      12'h008: return {24'b0, m_pend ? m_byte : m_last};
      12'h00C: return {24'b0, m_div};
      12'h010: return {30'b0, 1'b1, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(logic [11:0] a);
    if (a[11:5] == 7'h7F) return "R10 id";
    case (a)
      12'h000, 12'h00C: return "R2 readback";
      12'h004: return "R3 status";
      12'h008: return m_pend ? "R4 pop" : "R5 reread";
      12'h010: return "R7 irq status";
      default: return "R11 undefined read";
    endcase
  endfunction

  task automatic do_wr(logic [11:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 12'h008) begin
      chk("R9 strobe", {31'b0, tx_strobe}, 32'd1);
      chk("R9 data", {24'b0, tx_data}, {24'b0, d[7:0]});
    end else chk("R11 no strobe", {31'b0, tx_strobe}, 32'd0);
    if (a == 12'h000) m_ctrl = d[7:0];
    if (a == 12'h00C) m_div = d[7:0];
    idle();
    chk("R9 single cycle", {31'b0, tx_strobe}, 32'd0);
    chk_irq();
  endtask

  task automatic do_rd(logic [11:0] a);
    logic [31:0] e;
    string t;
    e = exp_rd(a); t = tag(a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(a == 12'h008 ? (m_pend ? "R4 ready" : "R5 no ready") : "R4 ready only on data",
        {31'b0, rx_ready}, {31'b0, a == 12'h008 && m_pend});
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    chk(t, bus_rdata, e);
    if (a == 12'h008 && m_pend) begin
      m_last = m_byte; m_pend = 0; rx_valid = 0;
    end
    idle();
    chk_irq();
  endtask

  task automatic offer(logic [7:0] b);
    rx_valid = 1; rx_data = b; m_byte = b;
    idle();
    m_pend = 1;
    idle();
    chk_irq();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CE5));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 strobe", {31'b0, tx_strobe}, 0);
    do_rd(12'h000); do_rd(12'h00C); do_rd(12'h008); do_rd(12'h004);
    // R2 upper bits dropped
    do_wr(12'h000, 32'hFFFF_FF00); do_rd(12'h000);
    do_wr(12'h00C, 32'h1234_56A5); do_rd(12'h00C);
    // R10 id window
    for (int i = 0; i < 8; i++) do_rd(12'hFE0 + 12'(i * 4));
    // R11 ignored writes and undefined reads
    do_wr(12'h000, 32'h0000_0010); do_wr(12'h00C, 32'h0000_0033);
    do_wr(12'h004, 32'hFFFF_FFFF); do_wr(12'h010, 32'hFFFF_FFFF);
    do_wr(12'hFE0, 32'hFFFF_FFFF); do_wr(12'h020, 32'hFFFF_FFFF);
    do_rd(12'h000); do_rd(12'h00C);
    do_rd(12'h014); do_rd(12'h800); do_rd(12'h002);
    // R4/R3 parity with odd and even bytes, R8 receive term
    offer(8'h01); do_rd(12'h004); do_rd(12'h010); do_rd(12'h008); do_rd(12'h004);
    offer(8'h03); do_rd(12'h008); do_rd(12'h004);
    // R5 re-read with nothing pending
    do_rd(12'h008);
    // R6 back-to-back pop then status read
    offer(8'hA7);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h008;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; bus_addr = 12'h004;
    #1 chk("R6 no second pop", {31'b0, rx_ready}, 0);
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    chk("R6 pend clear next cycle", bus_rdata & 32'h10, 0);
    m_last = 8'hA7; m_pend = 0;
    idle();
    // R9 transmit
    do_wr(12'h008, 32'hDEAD_BE5A);
    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: do_wr(12'h000, $urandom & 32'hFFFF_FF18 | ($urandom_range(0, 1) ? 32'h8 : 32'h0));
        1: do_wr(12'h00C, $urandom);
        2: if (!m_pend) offer(8'($urandom));
        3: do_rd(12'h008);
        4: do_rd(12'h004);
        5: do_rd(12'h010);
        default: do_wr(12'h008, $urandom);
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule